// File: doc/BRIEF.md
# Packed Lane Shifter

This unit takes a 64-bit word, views it as a set of equal packed lanes and shifts every lane by one shared count. Three shift kinds are offered: left with zero fill, arithmetic right that replicates the lane's own top bit, and logical right with zero fill. The lane size is picked per transfer, either four 16-bit lanes or two 32-bit lanes. No bit ever moves from one lane into a neighbour. The fill bits are confined to each lane.

The count comes either from a 64-bit general-register value or from an 8-bit immediate, chosen by a control bit. The count is unsigned. A count at or above the lane width produces an over-range result: all zeros for the two zero-fill shifts, and a lane full of copies of its sign bit for the arithmetic shift. For the register count, only the low 8 bits pick the shift amount. Any set bit above those 8 bits makes the count over-range.

Operands arrive on a valid/ready input stream and leave through a one-entry registered output stream. A result becomes visible one clock after its operand is accepted. The input is ready whenever the output register is empty or is being drained in the same cycle. While the consumer withholds `out_ready`, the held result and `out_valid` stay frozen and no new operand is taken. A new operand can be accepted in the same cycle the held result is drained, so a full-rate stream passes with no bubbles.

Top module: `lsh_simd_shifter`

## Requirements
- R1: After reset is asserted (active-low `rst_n`), `out_valid` is 0 and `in_ready` is 1.
- R2: An operand is accepted on a clock edge where `in_valid` and `in_ready` are both 1. Its result is on `out_data`, with `out_valid` at 1, after that edge. `in_ready` is 1 whenever `out_valid` is 0 or `out_ready` is 1.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold their values and `in_ready` is 0. A held result is released, and a waiting operand is taken, on the first edge where `out_ready` is 1.
- R4: `in_op` = 2'b00 shifts each lane left by the count. Vacated low bits of the lane are filled with 0.
- R5: `in_op` = 2'b01 shifts each lane right arithmetically. Vacated high bits of the lane are filled with that lane's bit of highest weight.
- R6: `in_op` = 2'b10 shifts each lane right logically. Vacated high bits of the lane are filled with 0.
- R7: `in_wide` = 0 selects four 16-bit lanes, bits [16k+15:16k] for k = 0..3. `in_wide` = 1 selects two 32-bit lanes, bits [32k+31:32k] for k = 0..1. No result bit of a lane depends on any other lane's input bits.
- R8: `in_use_imm` = 1 takes the count from `in_imm`, an 8-bit unsigned value. `in_use_imm` = 0 takes the count from `in_greg`, a 64-bit unsigned value. The source that is not selected has no effect.
- R9: A count of 16 or more with 16-bit lanes, or 32 or more with 32-bit lanes, is over-range. It gives 0 for the left and logical-right shifts, and all copies of the lane's sign bit for the arithmetic shift.
- R10: When `in_greg` is the source and any of its bits [63:8] is 1, the count is over-range, whatever its low 8 bits are.
- R11: A count of 0 returns the operand unchanged for every shift kind and lane size.
- R12: `in_op` = 2'b11 behaves exactly like the logical right shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand and controls are valid |
| in_ready | output | 1 | Unit can accept an operand this cycle |
| in_data | input | 64 | Packed lanes to be shifted |
| in_greg | input | 64 | Count from a general register |
| in_imm | input | 8 | Count from an immediate field |
| in_use_imm | input | 1 | 1 = use `in_imm`, 0 = use `in_greg` |
| in_wide | input | 1 | 0 = 16-bit lanes, 1 = 32-bit lanes |
| in_op | input | 2 | 00 left, 01 arithmetic right, 10 or 11 logical right |
| out_valid | output | 1 | `out_data` holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Shifted result |

## Verification
The assertions assume that the operand, count and control inputs are stable and known on every clock edge where `in_valid` is 1. The stimulus keeps to this by changing every input only on the falling clock edge. The stimulus also drops `in_valid` once a transfer is accepted, unless a back-pressure scenario is being tested. The assertions also assume that `out_ready` is never unknown once reset is released. The bench drives it as a plain 0 or 1 from time zero.

// File: rtl/lsh_pkg.sv
package lsh_pkg;

  // shift kind carried on in_op; the two logical codes share one behaviour
  typedef enum logic [1:0] {
    SH_LEFT      = 2'b00,
    SH_ARITH     = 2'b01,
    SH_LOGIC     = 2'b10,
    SH_LOGIC_ALT = 2'b11
  } shift_op_e;

  localparam int unsigned WORD_W   = 64;
  localparam int unsigned NARROW_W = 16;
  localparam int unsigned WIDE_W   = 32;
  localparam int unsigned IMM_W    = 8;
  localparam int unsigned EXAM_W   = 8;

endpackage

// File: rtl/lsh_count_unit.sv
// Resolves the shared shift count for both lane sizes: the amount bits
// that each lane shifter uses, and a flag when the count reaches the width.
module lsh_count_unit #(
  parameter int unsigned WORD_W   = 64,
  parameter int unsigned IMM_W    = 8,
  parameter int unsigned EXAM_W   = 8,
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned WIDE_W   = 32,
  localparam int unsigned NAMT_W  = $clog2(NARROW_W),
  localparam int unsigned WAMT_W  = $clog2(WIDE_W)
) (
  input  logic [WORD_W-1:0] greg_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  output logic [NAMT_W-1:0] amt_n_o,
  output logic              over_n_o,
  output logic [WAMT_W-1:0] amt_w_o,
  output logic              over_w_o
);

  logic [EXAM_W-1:0] low_cnt;
  logic              high_set;

  always_comb begin
    if (use_imm_i) begin
      low_cnt  = EXAM_W'(imm_i);
      high_set = 1'b0;
    end else begin
      low_cnt  = greg_i[EXAM_W-1:0];
      high_set = |greg_i[WORD_W-1:EXAM_W];
    end
  end

  assign amt_n_o  = low_cnt[NAMT_W-1:0];
  assign amt_w_o  = low_cnt[WAMT_W-1:0];
  assign over_n_o = high_set || (low_cnt >= EXAM_W'(NARROW_W));
  assign over_w_o = high_set || (low_cnt >= EXAM_W'(WIDE_W));

endmodule

// File: rtl/lsh_lane.sv
// One lane of width W: shifts by amt_i, or forces the over-range fill.
module lsh_lane
  import lsh_pkg::*;
#(
  parameter int unsigned W = 16,
  localparam int unsigned AMT_W = $clog2(W)
) (
  input  logic [W-1:0]     lane_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             over_i,
  input  shift_op_e        op_i,
  output logic [W-1:0]     lane_o
);

  logic signed [W-1:0] lane_s;
  logic [W-1:0]        sign_fill;

  assign lane_s    = lane_i;
  assign sign_fill = {W{lane_i[W-1]}};

  always_comb begin
    unique case (op_i)
      SH_LEFT:  lane_o = over_i ? '0 : (lane_i << amt_i);
      SH_ARITH: lane_o = over_i ? sign_fill : W'(lane_s >>> amt_i);
      default:  lane_o = over_i ? '0 : (lane_i >> amt_i);
    endcase
  end

endmodule

// File: rtl/lsh_simd_shifter.sv
// Packed lane shifter with valid/ready streams and a one-entry output register.
module lsh_simd_shifter
  import lsh_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W,
  parameter int unsigned CIMM_W = IMM_W,
  parameter int unsigned N_W    = NARROW_W,
  parameter int unsigned L_W    = WIDE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DATA_W-1:0] in_greg,
  input  logic [CIMM_W-1:0] in_imm,
  input  logic              in_use_imm,
  input  logic              in_wide,
  input  logic [1:0]        in_op,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  localparam int unsigned N_LANES = DATA_W / N_W;
  localparam int unsigned L_LANES = DATA_W / L_W;
  localparam int unsigned NAMT_W  = $clog2(N_W);
  localparam int unsigned LAMT_W  = $clog2(L_W);

  shift_op_e         op;
  logic [NAMT_W-1:0] amt_n;
  logic [LAMT_W-1:0] amt_w;
  logic              over_n, over_w;
  logic [DATA_W-1:0] res_n, res_w, res;
  logic              accept;

  assign op = shift_op_e'(in_op);

  lsh_count_unit #(
    .WORD_W  (DATA_W),
    .IMM_W   (CIMM_W),
    .EXAM_W  (EXAM_W),
    .NARROW_W(N_W),
    .WIDE_W  (L_W)
  ) u_cnt (
    .greg_i   (in_greg),
    .imm_i    (in_imm),
    .use_imm_i(in_use_imm),
    .amt_n_o  (amt_n),
    .over_n_o (over_n),
    .amt_w_o  (amt_w),
    .over_w_o (over_w)
  );

  for (genvar i = 0; i < N_LANES; i++) begin : g_narrow
    lsh_lane #(.W(N_W)) u_lane (
      .lane_i(in_data[i*N_W +: N_W]),
      .amt_i (amt_n),
      .over_i(over_n),
      .op_i  (op),
      .lane_o(res_n[i*N_W +: N_W])
    );
  end

  for (genvar i = 0; i < L_LANES; i++) begin : g_wide
    lsh_lane #(.W(L_W)) u_lane (
      .lane_i(in_data[i*L_W +: L_W]),
      .amt_i (amt_w),
      .over_i(over_w),
      .op_i  (op),
      .lane_o(res_w[i*L_W +: L_W])
    );
  end

  assign res      = in_wide ? res_w : res_n;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_data  <= res;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/lsh_simd_shifter_chk.sv
module lsh_simd_shifter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [63:0] in_data,
  input logic [63:0] in_greg,
  input logic [7:0]  in_imm,
  input logic        in_use_imm,
  input logic        in_wide,
  input logic [1:0]  in_op,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_data
);

  logic        acc;
  logic [63:0] cnt;
  logic [63:0] lim;

  assign acc = in_valid && in_ready;
  assign cnt = in_use_imm ? {56'd0, in_imm} : in_greg;
  assign lim = in_wide ? 64'd32 : 64'd16;

  assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_srl_over_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op[1] && (cnt >= lim)) |=> (out_data == 64'd0));

  assert_high_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_use_imm && (|in_greg[63:8]) && in_op == 2'b00) |=> (out_data == 64'd0));

  assert_zero_cnt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cnt == 64'd0) |=> (out_data == $past(in_data)));

endmodule

bind lsh_simd_shifter lsh_simd_shifter_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .in_greg   (in_greg),
  .in_imm    (in_imm),
  .in_use_imm(in_use_imm),
  .in_wide   (in_wide),
  .in_op     (in_op),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/sim_lsh_simd_shifter.sv
`timescale 1ns/1ps
module sim_lsh_simd_shifter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic [63:0] in_greg = '0;
  logic [7:0]  in_imm = '0;
  logic        in_use_imm = 1'b0;
  logic        in_wide = 1'b0;
  logic [1:0]  in_op = 2'b00;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lsh_simd_shifter u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_greg(in_greg), .in_imm(in_imm),
    .in_use_imm(in_use_imm), .in_wide(in_wide), .in_op(in_op),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Bitwise per-lane model written from the requirements.
  function automatic logic [63:0] model(input logic [63:0] d, input logic [63:0] g,
                                        input logic [7:0] im, input logic ui,
                                        input logic w, input logic [1:0] op);
    logic [63:0] r;
    logic [63:0] c;
    int lw;
    int sh;
    r  = '0;
    c  = ui ? {56'd0, im} : g;
    lw = w ? 32 : 16;
    sh = (c >= 64'(lw)) ? lw : int'(c[5:0]);
    for (int l = 0; l < 64 / lw; l++) begin
      for (int j = 0; j < lw; j++) begin
        int b;
        if (op == 2'b00) begin
          b = j - sh;
          r[l*lw + j] = (b >= 0) ? d[l*lw + b] : 1'b0;
        end else if (op == 2'b01) begin
          b = j + sh;
          r[l*lw + j] = (b < lw) ? d[l*lw + b] : d[l*lw + lw - 1];
        end else begin
          b = j + sh;
          r[l*lw + j] = (b < lw) ? d[l*lw + b] : 1'b0;
        end
      end
    end
    return r;
  endfunction

  task automatic xfer(input logic [63:0] d, input logic [63:0] g, input logic [7:0] im,
                      input logic ui, input logic w, input logic [1:0] op,
                      output logic [63:0] res);
    @(negedge clk);
    in_data = d; in_greg = g; in_imm = im; in_use_imm = ui; in_wide = w; in_op = op;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    res = out_valid ? out_data : 64'hDEAD_DEAD_DEAD_DEAD;
  endtask

  task automatic run(input string req, input logic [63:0] d, input logic [63:0] g,
                     input logic [7:0] im, input logic ui, input logic w, input logic [1:0] op);
    logic [63:0] res;
    xfer(d, g, im, ui, w, op, res);
    chk(req, res, model(d, g, im, ui, w, op));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 out_valid", {63'd0, out_valid}, 64'd0);
    chk("R1 in_ready", {63'd0, in_ready}, 64'd1);
  endtask

  task automatic t_left;
    logic [63:0] res;
    run("R4 left16", 64'h8001_4002_2003_1004, 64'd3, 8'd0, 1'b0, 1'b0, 2'b00);
    run("R4 left32", 64'h8000_0001_F0F0_1234, 64'd9, 8'd0, 1'b0, 1'b1, 2'b00);
    // R7: lanes full of ones, no carry into the neighbour's low bits
    xfer(64'hFFFF_FFFF_FFFF_FFFF, 64'd4, 8'd0, 1'b0, 1'b0, 2'b00, res);
    chk("R7 left16 contain", res, 64'hFFF0_FFF0_FFF0_FFF0);
    xfer(64'hFFFF_FFFF_FFFF_FFFF, 64'd4, 8'd0, 1'b0, 1'b1, 2'b00, res);
    chk("R7 left32 contain", res, 64'hFFFF_FFF0_FFFF_FFF0);
  endtask

  task automatic t_arith;
    logic [63:0] res;
    run("R5 arith16", 64'h8000_7FFF_C3A5_0F0F, 64'd5, 8'd0, 1'b0, 1'b0, 2'b01);
    run("R5 arith32", 64'h8765_4321_7654_3210, 64'd12, 8'd0, 1'b0, 1'b1, 2'b01);
    xfer(64'h8000_0000_8000_0000, 64'd4, 8'd0, 1'b0, 1'b0, 2'b01, res);
    chk("R7 arith16 contain", res, 64'hF800_0000_F800_0000);
  endtask

  task automatic t_logic;
    run("R6 logic16", 64'h8000_FFFF_1234_ABCD, 64'd7, 8'd0, 1'b0, 1'b0, 2'b10);
    run("R6 logic32", 64'hFFFF_0000_8000_0001, 64'd31, 8'd0, 1'b0, 1'b1, 2'b10);
    run("R12 alt code", 64'hF00D_BEEF_8421_C0DE, 64'd6, 8'd0, 1'b0, 1'b0, 2'b11);
  endtask

  task automatic t_source;
    logic [63:0] res;
    xfer(64'h0001_0001_0001_0001, 64'd100, 8'd3, 1'b1, 1'b0, 2'b00, res);
    chk("R8 imm chosen", res, 64'h0008_0008_0008_0008);
    xfer(64'h0001_0001_0001_0001, 64'd2, 8'd200, 1'b0, 1'b0, 2'b00, res);
    chk("R8 greg chosen", res, 64'h0004_0004_0004_0004);
    run("R8 imm wide", 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF, 8'd17, 1'b1, 1'b1, 2'b01);
  endtask

  task automatic t_over;
    logic [63:0] res;
    xfer(64'h8001_7FFF_FFFF_0001, 64'd16, 8'd0, 1'b0, 1'b0, 2'b01, res);
    chk("R9 arith16 at 16", res, 64'hFFFF_0000_FFFF_0000);
    xfer(64'h8001_7FFF_FFFF_0001, 64'd16, 8'd0, 1'b0, 1'b0, 2'b00, res);
    chk("R9 left16 at 16", res, 64'd0);
    xfer(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 8'd32, 1'b1, 1'b1, 2'b10, res);
    chk("R9 logic32 at 32", res, 64'd0);
    xfer(64'h8000_0000_7FFF_FFFF, 64'd0, 8'd255, 1'b1, 1'b1, 2'b01, res);
    chk("R9 arith32 imm 255", res, 64'hFFFF_FFFF_0000_0000);
    run("R9 left32 at 31", 64'hFFFF_FFFF_FFFF_FFFF, 64'd31, 8'd0, 1'b0, 1'b1, 2'b00);
    run("R9 logic16 at 15", 64'hFFFF_8000_7FFF_0001, 64'd15, 8'd0, 1'b0, 1'b0, 2'b10);
  endtask

  task automatic t_high;
    logic [63:0] res;
    xfer(64'h1111_2222_3333_4444, 64'h0000_0000_0000_0102, 8'd0, 1'b0, 1'b0, 2'b00, res);
    chk("R10 bit8 left", res, 64'd0);
    xfer(64'h8000_0001_1111_1111, 64'h8000_0000_0000_0001, 8'd0, 1'b0, 1'b1, 2'b01, res);
    chk("R10 bit63 arith", res, 64'hFFFF_FFFF_0000_0000);
  endtask

  task automatic t_zero;
    logic [63:0] res;
    xfer(64'h8123_4567_89AB_CDEF, 64'd0, 8'd0, 1'b0, 1'b0, 2'b01, res);
    chk("R11 zero arith16", res, 64'h8123_4567_89AB_CDEF);
    xfer(64'h8123_4567_89AB_CDEF, 64'd77, 8'd0, 1'b1, 1'b1, 2'b10, res);
    chk("R11 zero imm logic32", res, 64'h8123_4567_89AB_CDEF);
  endtask

  task automatic t_backpressure;
    logic [63:0] a_exp, b_exp;
    a_exp = model(64'h0F0F_0F0F_0F0F_0F0F, 64'd1, 8'd0, 1'b0, 1'b0, 2'b00);
    b_exp = model(64'hF000_000F_F000_000F, 64'd2, 8'd0, 1'b0, 1'b1, 2'b10);
    @(negedge clk);
    out_ready = 1'b0;
    in_data = 64'h0F0F_0F0F_0F0F_0F0F; in_greg = 64'd1; in_use_imm = 1'b0;
    in_wide = 1'b0; in_op = 2'b00; in_valid = 1'b1;
    @(negedge clk);
    chk("R2 valid after accept", {63'd0, out_valid}, 64'd1);
    chk("R2 data after accept", out_data, a_exp);
    in_data = 64'hF000_000F_F000_000F; in_greg = 64'd2; in_wide = 1'b1; in_op = 2'b10;
    chk("R3 not ready", {63'd0, in_ready}, 64'd0);
    repeat (3) @(negedge clk);
    chk("R3 held valid", {63'd0, out_valid}, 64'd1);
    chk("R3 held data", out_data, a_exp);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R3 next taken", out_data, b_exp);
    chk("R3 next valid", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    chk("R2 drained", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_left();
    t_arith();
    t_logic();
    t_source();
    t_over();
    t_high();
    t_zero();
    t_backpressure();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule